// File: doc/BRIEF.md
# Vector Length Set Unit

This unit carries out the instruction that sets the vector length. It holds two small architectural values: the active vector length (VL) and the maximum vector length (MVL). Each instruction it executes may load a new MVL from its 7-bit immediate. It then picks a candidate VL from one of four sources, in strict priority order:

1. the VL already held,
2. the low bits of a source register,
3. the immediate,
4. a 64-bit count register, saturated to the largest 7-bit value.

The candidate is clamped so that it never exceeds MVL. The result is stored and also returned for writing to the destination register.

The decoder presents the instruction fields, the source register value and the count register value together with an execute strobe. The register-file write request (enable, index, data) follows from those inputs in the same cycle. The new VL and MVL are stored at the clock edge that ends the strobed cycle. Register-file storage, decoding and condition flags belong to other blocks.

Top module: `vlen_set_unit`

## Requirements
- R1: While reset is asserted and at the first edge after it is released, both the held VL and the held MVL read 0.
- R2: With set_vl low, the candidate VL is the VL already held. It is still clamped against the effective MVL.
- R3: With set_vl high and src_idx nonzero, the candidate VL is src_val[6:0]. Bits 63..7 of src_val have no effect.
- R4: With set_vl high, src_idx zero and dst_idx zero, the candidate VL is len_imm.
- R5: With set_vl high, src_idx zero and dst_idx nonzero (count mode), the candidate VL is 127 when count_val, taken as unsigned, exceeds 127. Otherwise it is count_val[6:0].
- R6: The stored VL is never larger than the effective MVL: min(candidate, effective MVL).
- R7: With set_mvl high, the effective MVL is len_imm. It is used for the clamp of the same instruction and stored as MVL. With set_mvl low, the held MVL is used and kept.
- R8: wb_en is high only when exec_valid is high and dst_idx is nonzero. wb_idx equals dst_idx. wb_data is the final VL, zero-extended to 64 bits.
- R9: VL and MVL change only at a clock edge where exec_valid is high. With exec_valid low, neither changes, whatever the other inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| exec_valid | input | 1 | Instruction present in this cycle |
| dst_idx | input | 5 | Destination register index |
| src_idx | input | 5 | Source register index |
| len_imm | input | 7 | Length immediate |
| set_vl | input | 1 | Select a new VL from register, immediate or count |
| set_mvl | input | 1 | Load MVL from the immediate |
| src_val | input | 64 | Value of the source register |
| count_val | input | 64 | Value of the count register |
| vl_q | output | 7 | Held vector length |
| mvl_q | output | 7 | Held maximum vector length |
| wb_en | output | 1 | Destination register write request |
| wb_idx | output | 5 | Destination register index for the write |
| wb_data | output | 64 | Final VL, zero-extended |

## Verification
Two functions can act in the same instruction: loading MVL from the immediate, and clamping the selected VL. The clamp must therefore see the freshly loaded MVL, not the held one. The bench provokes this in count mode with a small held MVL, a larger immediate and a moderate count, so that only the new MVL lets the count through. It also provokes it in the opposite direction: set_vl low, with an immediate smaller than the held VL. In both cases it compares the write-back data in the strobed cycle, and the held VL and MVL after the edge, against values derived from the requirements.

// File: rtl/vlen_pkg.sv
package vlen_pkg;
  parameter int unsigned VLEN_W = 7;

  typedef enum logic [1:0] {
    SRC_HELD  = 2'd0,
    SRC_REG   = 2'd1,
    SRC_IMM   = 2'd2,
    SRC_COUNT = 2'd3
  } vl_src_e;

  typedef struct packed {
    logic [VLEN_W-1:0] vl;
    logic [VLEN_W-1:0] mvl;
  } vl_state_t;
endpackage

// File: rtl/vlen_src_select.sv
module vlen_src_select
  import vlen_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned IDX_W = 5
) (
  input  logic              set_vl,
  input  logic [IDX_W-1:0]  dst_idx,
  input  logic [IDX_W-1:0]  src_idx,
  input  logic [VLEN_W-1:0] len_imm,
  input  logic [XLEN-1:0]   src_val,
  input  logic [XLEN-1:0]   count_val,
  input  logic [VLEN_W-1:0] held_vl,
  output vl_src_e           src_sel,
  output logic [VLEN_W-1:0] vl_cand
);
  localparam int unsigned HI_W = XLEN - VLEN_W;
  localparam logic [VLEN_W-1:0] VL_SAT = {VLEN_W{1'b1}};

  logic              count_over;
  logic [VLEN_W-1:0] count_sat;

  // Count exceeds the largest VL when any bit above the VL field is set
  assign count_over = |count_val[XLEN-1:VLEN_W];
  assign count_sat  = count_over ? VL_SAT : count_val[VLEN_W-1:0];

  always_comb begin
    if (!set_vl)                src_sel = SRC_HELD;
    else if (src_idx != '0)     src_sel = SRC_REG;
    else if (dst_idx == '0)     src_sel = SRC_IMM;
    else                        src_sel = SRC_COUNT;
  end

  always_comb begin
    unique case (src_sel)
      SRC_HELD:  vl_cand = held_vl;
      SRC_REG:   vl_cand = src_val[VLEN_W-1:0];
      SRC_IMM:   vl_cand = len_imm;
      default:   vl_cand = count_sat;
    endcase
  end

  // R5: saturation never yields a value below the count's low field
  always_comb begin
    if (src_sel == SRC_COUNT && HI_W > 0) begin
      assert_count_sat_R5: assert (count_sat >= count_val[VLEN_W-1:0]);
    end
  end
endmodule

// File: rtl/vlen_clamp.sv
module vlen_clamp
  import vlen_pkg::*;
(
  input  logic              set_mvl,
  input  logic [VLEN_W-1:0] len_imm,
  input  logic [VLEN_W-1:0] held_mvl,
  input  logic [VLEN_W-1:0] vl_cand,
  output logic [VLEN_W-1:0] mvl_eff,
  output logic [VLEN_W-1:0] vl_final
);
  logic over;

  assign mvl_eff  = set_mvl ? len_imm : held_mvl;
  assign over     = vl_cand > mvl_eff;
  assign vl_final = over ? mvl_eff : vl_cand;

  // R6: the clamped value never exceeds the limit it was clamped against
  always_comb begin
    assert_clamp_bound_R6: assert (vl_final <= mvl_eff);
  end
endmodule

// File: rtl/vlen_state_reg.sv
module vlen_state_reg
  import vlen_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_valid,
  input  logic [VLEN_W-1:0] vl_final,
  input  logic [VLEN_W-1:0] mvl_eff,
  output vl_state_t         state_q
);
  vl_state_t state_d;
  logic      state_en;

  assign state_en = exec_valid;

  always_comb begin
    state_d     = state_q;
    state_d.vl  = vl_final;
    state_d.mvl = mvl_eff;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= '0;
    end else if (state_en) begin
      state_q <= state_d;
    end
  end

  property p_reset_clear;
    @(posedge clk) $rose(rst_n) |-> (state_q.vl == '0 && state_q.mvl == '0);
  endproperty
  assert_reset_clear_R1: assert property (p_reset_clear);

  property p_hold_idle;
    @(posedge clk) disable iff (!rst_n)
      !exec_valid |=> $stable(state_q);
  endproperty
  assert_hold_idle_R9: assert property (p_hold_idle);
endmodule

// File: rtl/vlen_set_unit.sv
module vlen_set_unit
  import vlen_pkg::*;
#(
  parameter int unsigned XLEN  = 64,
  parameter int unsigned IDX_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              exec_valid,
  input  logic [IDX_W-1:0]  dst_idx,
  input  logic [IDX_W-1:0]  src_idx,
  input  logic [VLEN_W-1:0] len_imm,
  input  logic              set_vl,
  input  logic              set_mvl,
  input  logic [XLEN-1:0]   src_val,
  input  logic [XLEN-1:0]   count_val,
  output logic [VLEN_W-1:0] vl_q,
  output logic [VLEN_W-1:0] mvl_q,
  output logic              wb_en,
  output logic [IDX_W-1:0]  wb_idx,
  output logic [XLEN-1:0]   wb_data
);
  localparam int unsigned PAD_W = XLEN - VLEN_W;

  vl_src_e           src_sel;
  logic [VLEN_W-1:0] vl_cand;
  logic [VLEN_W-1:0] mvl_eff;
  logic [VLEN_W-1:0] vl_final;
  vl_state_t         state_q;

  vlen_src_select #(.XLEN(XLEN), .IDX_W(IDX_W)) sel_i (
    .set_vl   (set_vl),
    .dst_idx  (dst_idx),
    .src_idx  (src_idx),
    .len_imm  (len_imm),
    .src_val  (src_val),
    .count_val(count_val),
    .held_vl  (state_q.vl),
    .src_sel  (src_sel),
    .vl_cand  (vl_cand)
  );

  vlen_clamp clamp_i (
    .set_mvl (set_mvl),
    .len_imm (len_imm),
    .held_mvl(state_q.mvl),
    .vl_cand (vl_cand),
    .mvl_eff (mvl_eff),
    .vl_final(vl_final)
  );

  vlen_state_reg state_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .exec_valid(exec_valid),
    .vl_final  (vl_final),
    .mvl_eff   (mvl_eff),
    .state_q   (state_q)
  );

  assign vl_q    = state_q.vl;
  assign mvl_q   = state_q.mvl;
  assign wb_en   = exec_valid && (dst_idx != '0);
  assign wb_idx  = dst_idx;
  assign wb_data = {{PAD_W{1'b0}}, vl_final};

  property p_state_bound;
    @(posedge clk) disable iff (!rst_n) vl_q <= mvl_q;
  endproperty
  assert_state_bound_R6: assert property (p_state_bound);

  property p_wb_stored;
    @(posedge clk) disable iff (!rst_n)
      wb_en |=> (vl_q == $past(wb_data[VLEN_W-1:0]));
  endproperty
  assert_wb_stored_R8: assert property (p_wb_stored);

  property p_wb_zero_ext;
    @(posedge clk) disable iff (!rst_n)
      wb_en |-> (wb_data[XLEN-1:VLEN_W] == '0);
  endproperty
  assert_wb_zero_ext_R8: assert property (p_wb_zero_ext);

  property p_mvl_load;
    @(posedge clk) disable iff (!rst_n)
      (exec_valid && set_mvl) |=> (mvl_q == $past(len_imm));
  endproperty
  assert_mvl_load_R7: assert property (p_mvl_load);

  property p_count_big;
    @(posedge clk) disable iff (!rst_n)
      (exec_valid && set_vl && src_idx == '0 && dst_idx != '0 &&
       count_val[XLEN-1:VLEN_W] != '0)
      |-> (wb_data[VLEN_W-1:0] == (set_mvl ? len_imm : mvl_q));
  endproperty
  assert_count_big_R5: assert property (p_count_big);
endmodule

// File: tb/vlen_set_unit_tb_top.sv
module vlen_set_unit_tb_top;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG_CYCLES = 5000;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        exec_valid;
  logic [4:0]  dst_idx, src_idx;
  logic [6:0]  len_imm;
  logic        set_vl, set_mvl;
  logic [63:0] src_val, count_val;
  logic [6:0]  vl_q, mvl_q;
  logic        wb_en;
  logic [4:0]  wb_idx;
  logic [63:0] wb_data;

  int checks = 0;
  int fails  = 0;
  int unsigned exp_vl  = 0;
  int unsigned exp_mvl = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vlen_set_unit dut_i (
    .clk(clk), .rst_n(rst_n), .exec_valid(exec_valid),
    .dst_idx(dst_idx), .src_idx(src_idx), .len_imm(len_imm),
    .set_vl(set_vl), .set_mvl(set_mvl), .src_val(src_val),
    .count_val(count_val), .vl_q(vl_q), .mvl_q(mvl_q),
    .wb_en(wb_en), .wb_idx(wb_idx), .wb_data(wb_data)
  );

  task automatic check(input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic idle_inputs();
    exec_valid = 1'b0; dst_idx = '0; src_idx = '0; len_imm = '0;
    set_vl = 1'b0; set_mvl = 1'b0; src_val = '0; count_val = '0;
  endtask

  // Runs one instruction; expectations come from the requirement text
  task automatic run_instr(input string req, input bit sv, input bit sm,
                           input int unsigned d, input int unsigned s,
                           input int unsigned imm, input longint unsigned sval,
                           input longint unsigned cval);
    int unsigned cand, lim, fin;
    @(negedge clk);
    exec_valid = 1'b1; set_vl = sv; set_mvl = sm;
    dst_idx = 5'(d); src_idx = 5'(s); len_imm = 7'(imm);
    src_val = sval; count_val = cval;
    if (!sv)            cand = exp_vl;
    else if (s != 0)    cand = int'(sval & 64'h7f);
    else if (d == 0)    cand = imm;
    else if (cval > 127) cand = 127;
    else                cand = int'(cval);
    lim = sm ? imm : exp_mvl;
    fin = (cand > lim) ? lim : cand;
    #1;
    check(req, "wb_en", wb_en, (d != 0) ? 1 : 0);
    if (d != 0) begin
      check(req, "wb_idx", wb_idx, d);
      check(req, "wb_data", wb_data, fin);
    end
    @(posedge clk);
    @(negedge clk);
    idle_inputs();
    exp_vl = fin; exp_mvl = lim;
    check(req, "vl_q", vl_q, exp_vl);
    check(req, "mvl_q", mvl_q, exp_mvl);
  endtask

  task automatic t_reset();
    rst_n = 1'b0; idle_inputs();
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1", "vl_q in reset", vl_q, 0);
    check("R1", "mvl_q in reset", mvl_q, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", "vl_q after release", vl_q, 0);
    check("R1", "mvl_q after release", mvl_q, 0);
    exp_vl = 0; exp_mvl = 0;
  endtask

  task automatic t_imm_mode();
    run_instr("R4", 1, 1, 0, 0, 10, 64'h55, 64'h33);
    check("R4", "imm vl", vl_q, 10);
    run_instr("R4", 1, 1, 0, 0, 2, 0, 0);
  endtask

  task automatic t_count_small();
    // held VL=2 MVL=2, imm 10 loads MVL, count 5 passes the new limit
    run_instr("R7", 1, 1, 1, 0, 10, 0, 5);
    check("R5", "count vl", vl_q, 5);
    check("R7", "mvl loaded", mvl_q, 10);
  endtask

  task automatic t_count_large();
    run_instr("R5", 1, 1, 1, 0, 10, 0, 64'h10_0000_0000);
    check("R6", "saturated then clamped", vl_q, 10);
    run_instr("R5", 1, 1, 2, 0, 127, 0, 64'h80);
    check("R5", "0x80 saturates", vl_q, 127);
    run_instr("R5", 1, 0, 2, 0, 0, 0, 127);
    check("R5", "127 passes", vl_q, 127);
    run_instr("R5", 1, 0, 2, 0, 0, 0, 64'hFFFF_FFFF_FFFF_FFFF);
  endtask

  task automatic t_reg_mode();
    run_instr("R3", 1, 0, 4, 3, 99, 64'hFFFF_FFFF_FFFF_FF05, 64'h7);
    check("R3", "upper bits ignored", vl_q, 5);
    run_instr("R8", 1, 0, 0, 6, 0, 64'd20, 0);
    check("R8", "no wb for dst 0", wb_en, 0);
    run_instr("R7", 1, 1, 5, 9, 10, 64'd50, 0);
    run_instr("R6", 1, 0, 5, 9, 0, 64'd60, 0);
    check("R6", "clamped to held mvl", vl_q, 10);
  endtask

  task automatic t_held_mode();
    run_instr("R2", 0, 1, 7, 0, 3, 64'd1, 64'd1);
    check("R2", "held vl shrinks with mvl", vl_q, 3);
    run_instr("R2", 0, 0, 7, 4, 100, 64'd1, 64'd1);
    check("R2", "held vl kept", vl_q, 3);
  endtask

  task automatic t_idle();
    @(negedge clk);
    exec_valid = 1'b0; set_vl = 1'b1; set_mvl = 1'b1; dst_idx = 5'd9;
    src_idx = 5'd2; len_imm = 7'd77; src_val = 64'd40; count_val = 64'd40;
    #1;
    check("R8", "idle wb_en", wb_en, 0);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R9", "idle vl", vl_q, exp_vl);
    check("R9", "idle mvl", mvl_q, exp_mvl);
    idle_inputs();
  endtask

  initial begin
    t_reset();
    t_imm_mode();
    t_count_small();
    t_count_large();
    t_reg_mode();
    t_held_mode();
    t_idle();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < WATCHDOG_CYCLES && !done; i++) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule